// File: doc/BRIEF.md
# Adaptive F2F Bit Decoder

This block turns a logic-level F2F (two-frequency, biphase) stream from a magnetic stripe read channel into serial data bits. A card swipe begins with a run of zero bits. The decoder uses those lead-in cells only to learn how long one bit lasts, and decodes nothing from them. After the lead-in, it classifies each cell from the arrival time of the first transition after the cell boundary. An early transition is a mid-cell transition, so the cell is a 1. A late transition is the next boundary, so the cell is a 0. The threshold is 70% of a reference length. That reference is always the floor average of the two previous cell lengths, so the decoder follows the swipe as it speeds up or slows down.

The decoder drives an active-low card-present flag. It presents each decoded bit, and the bit's complement, once the start of the following cell has been found, and marks each new bit with a one-cycle strobe. After reset, a start-up delay of a parameterised number of microseconds must pass before the decoder accepts transitions. A long quiet period on the input ends the card and returns the decoder to hunting for a new lead-in. Both delays count a microsecond tick derived from the system clock.

Top module: `f2f_bit_decoder`

## Requirements
- R1: While reset is low and right after it, card_present_n is 1, bit_strobe is 0, bit_out is 0 and bit_out_n is 1.
- R2: Input transitions during the first STARTUP_US microseconds after reset release are ignored. They do not assert card_present_n and they produce no bit_strobe.
- R3: skip_long = 0 selects 4 lead-in cells and skip_long = 1 selects 8. Every transition during the lead-in is a cell boundary. card_present_n falls on the transition that ends the last lead-in cell, and is visible at the third rising clock edge after that input change.
- R4: The reference for the first data cell is the length of the last lead-in cell only. Earlier lead-in cells do not affect it.
- R5: After the first data cell, the reference is (len_prev + len_prior) >> 1. Here len_prev and len_prior are the lengths in clock cycles of the two previous cells, and the division rounds down.
- R6: If the first transition in a cell comes after e clock cycles with 10*e < 7*reference, the cell decodes as 1. The next transition after it ends the cell.
- R7: If the first transition in a cell comes after e clock cycles with 10*e >= 7*reference, the cell decodes as 0. That same transition ends the cell.
- R8: Each data bit appears on bit_out, with its complement on bit_out_n, together with a one-cycle bit_strobe. The strobe is high at the third rising edge after the input transition that ends the cell. bit_out holds its value between strobes. The bits come out in order, exactly one per data cell.
- R9: When no transition arrives for TIMEOUT_US microseconds, card_present_n returns to 1 and the next transition starts a new lead-in. No bit_strobe occurs while card_present_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| f2f_in | input | 1 | Asynchronous F2F data level from the read channel |
| skip_long | input | 1 | Lead-in length select: 0 selects 4 cells, 1 selects 8 cells |
| card_present_n | output | 1 | Low while a card is being decoded (after the lead-in) |
| bit_out | output | 1 | Most recently decoded data bit |
| bit_out_n | output | 1 | Complement of bit_out |
| bit_strobe | output | 1 | One-cycle pulse when a new bit is placed on bit_out |

## Verification
A wrong length history or reference does not show up at the ports straight away. It appears when a later cell has a transition close to the 70% point and the cell decodes to the wrong value, which is usually within two or three cells. A wrong cell counter or boundary decision affects the very next cell: the decoder reports one bit too few or too many, and every later bit of the card is misaligned. A wrong lead-in count or timeout state shows up at card_present_n, either on the transition that should end the lead-in or about TIMEOUT_US after the last transition.

// File: rtl/f2f_pkg.sv
// Package: shared types for the F2F bit decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package f2f_pkg;

    // Decoder phase: waiting for a card, learning the cell length, decoding data
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_DATA = 2'd2
    } dec_phase_t;

endpackage

// File: rtl/f2f_edge_sync.sv
// Module: f2f_edge_sync
// Brings the asynchronous F2F level into the clock domain through a flop chain.
// Emits a one-cycle pulse on each change of the synchronised level.
// Assumes: the input stays stable for several clock cycles between changes.
module f2f_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic toggle_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // Synchroniser chain with one flop per stage
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[SYNC_STAGES-1];
    end

    // A difference between the current and previous level is a transition
    assign toggle_o = chain_q[SYNC_STAGES-1] ^ last_q;

endmodule

// File: rtl/f2f_us_timer.sv
// Module: f2f_us_timer
// Derives a microsecond tick from the clock and times the start-up delay and the quiet interval.
// ready_o rises STARTUP_US ticks after reset. quiet_o is high once TIMEOUT_US ticks pass with no transition.
// Assumes: CLK_PER_US >= 1, STARTUP_US >= 1, TIMEOUT_US >= 1.
module f2f_us_timer #(
    parameter int CLK_PER_US = 50,
    parameter int STARTUP_US = 10000,
    parameter int TIMEOUT_US = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    output logic ready_o,
    output logic quiet_o
);

    localparam int PRE_W = $clog2(CLK_PER_US + 1);
    localparam int STU_W = $clog2(STARTUP_US + 1);
    localparam int TMO_W = $clog2(TIMEOUT_US + 1);

    logic [PRE_W-1:0] pre_q;
    logic [STU_W-1:0] stu_q;
    logic [TMO_W-1:0] tmo_q;
    logic             tick;

    assign tick = (pre_q == PRE_W'(CLK_PER_US - 1));

    // Free-running prescaler from clock cycles to microseconds
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + PRE_W'(1);
    end

    // Start-up delay after reset; ready stays high from then on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stu_q   <= '0;
            ready_o <= 1'b0;
        end else if (!ready_o && tick) begin
            if (stu_q == STU_W'(STARTUP_US - 1)) ready_o <= 1'b1;
            else                                 stu_q   <= stu_q + STU_W'(1);
        end
    end

    // Microseconds since the last transition, saturating at the timeout
    always_ff @(posedge clk) begin
        if (!rst_n)                                   tmo_q <= '0;
        else if (toggle_i)                            tmo_q <= '0;
        else if (tick && tmo_q != TMO_W'(TIMEOUT_US)) tmo_q <= tmo_q + TMO_W'(1);
    end

    assign quiet_o = (tmo_q == TMO_W'(TIMEOUT_US));

endmodule

// File: rtl/f2f_cell_decoder.sv
// Module: f2f_cell_decoder
// Measures cell lengths, learns the reference from the lead-in and classifies each data cell.
// A cell is 1 if its first transition arrives before 70% of the reference, and 0 otherwise.
// The reference is the floor average of the two previous cell lengths.
// Assumes: toggle_i is already qualified by the start-up delay; lead-in cells are all zeros.
module f2f_cell_decoder
    import f2f_pkg::*;
#(
    parameter int CELL_W     = 16,
    parameter int SKIP_SHORT = 4,
    parameter int SKIP_LONG  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    input  logic quiet_i,
    input  logic skip_long_i,
    output logic card_n_o,
    output logic bit_o,
    output logic strobe_o
);

    localparam int SK_W  = $clog2(SKIP_LONG + 1);
    localparam int MUL_W = CELL_W + 4;

    dec_phase_t        phase_q;
    logic [SK_W-1:0]   skip_cnt_q;
    logic [SK_W-1:0]   skip_tgt_q;
    logic [CELL_W-1:0] cell_q;
    logic [CELL_W-1:0] len_prev_q;
    logic [CELL_W-1:0] len_prior_q;
    logic              mid_q;
    logic [CELL_W:0]   len_sum;
    logic [CELL_W-1:0] ref_len;
    logic [MUL_W-1:0]  elapsed_x10;
    logic [MUL_W-1:0]  ref_x7;
    logic              early;
    logic              boundary;

    // Reference length and the 70% comparison done in integers
    always_comb begin
        len_sum     = {1'b0, len_prev_q} + {1'b0, len_prior_q};
        ref_len     = len_sum[CELL_W:1];
        elapsed_x10 = MUL_W'(cell_q) * MUL_W'(10);
        ref_x7      = MUL_W'(ref_len) * MUL_W'(7);
        early       = (elapsed_x10 < ref_x7);
        boundary    = (phase_q != PH_DATA) || mid_q || !early;
    end

    // Cell timer counts clocks since the last cell boundary, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                       cell_q <= CELL_W'(1);
        else if (toggle_i && boundary)    cell_q <= CELL_W'(1);
        else if (cell_q != '1)            cell_q <= cell_q + CELL_W'(1);
    end

    // Phase sequencing, length history, bit classification and output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            skip_cnt_q  <= '0;
            skip_tgt_q  <= SK_W'(SKIP_SHORT);
            len_prev_q  <= '0;
            len_prior_q <= '0;
            mid_q       <= 1'b0;
            card_n_o    <= 1'b1;
            bit_o       <= 1'b0;
            strobe_o    <= 1'b0;
        end else begin
            strobe_o <= 1'b0;
            if (toggle_i) begin
                unique case (phase_q)
                    PH_IDLE: begin
                        phase_q    <= PH_LEAD;
                        skip_cnt_q <= '0;
                        skip_tgt_q <= skip_long_i ? SK_W'(SKIP_LONG) : SK_W'(SKIP_SHORT);
                        mid_q      <= 1'b0;
                    end
                    PH_LEAD: begin
                        if (skip_cnt_q == skip_tgt_q - SK_W'(1)) begin
                            phase_q     <= PH_DATA;
                            card_n_o    <= 1'b0;
                            len_prev_q  <= cell_q;
                            len_prior_q <= cell_q;
                        end else begin
                            skip_cnt_q <= skip_cnt_q + SK_W'(1);
                        end
                    end
                    PH_DATA: begin
                        if (mid_q || !early) begin
                            bit_o       <= mid_q;
                            strobe_o    <= 1'b1;
                            len_prior_q <= len_prev_q;
                            len_prev_q  <= cell_q;
                            mid_q       <= 1'b0;
                        end else begin
                            mid_q <= 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end else if (quiet_i && phase_q != PH_IDLE) begin
                phase_q  <= PH_IDLE;
                card_n_o <= 1'b1;
                mid_q    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/f2f_bit_decoder.sv
// Module: f2f_bit_decoder (top)
// Decodes a logic-level F2F stream into serial bits with a card-present flag.
// Chain: synchroniser and edge detector, microsecond timer, adaptive cell decoder.
// Assumes: f2f_in is asynchronous and changes no faster than a few clock cycles apart.
module f2f_bit_decoder #(
    parameter int CLK_PER_US  = 50,
    parameter int STARTUP_US  = 10000,
    parameter int TIMEOUT_US  = 12500,
    parameter int CELL_W      = 16,
    parameter int SKIP_SHORT  = 4,
    parameter int SKIP_LONG   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic f2f_in,
    input  logic skip_long,
    output logic card_present_n,
    output logic bit_out,
    output logic bit_out_n,
    output logic bit_strobe
);

    logic edge_raw;
    logic ready;
    logic quiet;
    logic edge_ok;

    f2f_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (f2f_in),
        .toggle_o (edge_raw)
    );

    f2f_us_timer #(
        .CLK_PER_US(CLK_PER_US),
        .STARTUP_US(STARTUP_US),
        .TIMEOUT_US(TIMEOUT_US)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle_i (edge_raw),
        .ready_o  (ready),
        .quiet_o  (quiet)
    );

    // Transitions only count once the start-up delay is over
    assign edge_ok = edge_raw && ready;

    f2f_cell_decoder #(
        .CELL_W    (CELL_W),
        .SKIP_SHORT(SKIP_SHORT),
        .SKIP_LONG (SKIP_LONG)
    ) dec_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .toggle_i    (edge_ok),
        .quiet_i     (quiet),
        .skip_long_i (skip_long),
        .card_n_o    (card_present_n),
        .bit_o       (bit_out),
        .strobe_o    (bit_strobe)
    );

    assign bit_out_n = ~bit_out;

endmodule

// File: rtl/f2f_decoder_chk.sv
// Module: f2f_decoder_chk
// Temporal checks on the decoder ports and on the internal transition and ready signals.
// Bound to f2f_bit_decoder below.
module f2f_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic edge_seen,
    input logic ready,
    input logic card_present_n,
    input logic bit_strobe,
    input logic bit_out
);

    // R2
    startup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> card_present_n);

    // R3
    card_load_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_present_n) |-> $past(edge_seen));

    // R8
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_strobe |-> $stable(bit_out));

    // R8
    strobe_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> $past(edge_seen));

    // R9
    strobe_needs_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> !card_present_n);

endmodule

bind f2f_bit_decoder f2f_decoder_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .edge_seen      (edge_raw),
    .ready          (ready),
    .card_present_n (card_present_n),
    .bit_strobe     (bit_strobe),
    .bit_out        (bit_out)
);

// File: tb/f2f_bit_decoder_tb.sv
module f2f_bit_decoder_tb_top;

    localparam int K_CLK = 2;
    localparam int K_STU = 20;
    localparam int K_TMO = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f2f_in = 1'b0;
    logic skip_long = 1'b0;
    logic card_present_n;
    logic bit_out;
    logic bit_out_n;
    logic bit_strobe;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit exp_bits [0:1023];
    int exp_cnt = 0;
    int rx_cnt = 0;

    always #10 clk = ~clk;

    f2f_bit_decoder #(
        .CLK_PER_US(K_CLK),
        .STARTUP_US(K_STU),
        .TIMEOUT_US(K_TMO),
        .CELL_W    (12)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .f2f_in         (f2f_in),
        .skip_long      (skip_long),
        .card_present_n (card_present_n),
        .bit_out        (bit_out),
        .bit_out_n      (bit_out_n),
        .bit_strobe     (bit_strobe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Compare every strobed bit with the expected sequence (R8, R6, R7)
    always @(negedge clk) begin
        if (rst_n && bit_strobe) begin
            if (rx_cnt < exp_cnt) begin
                check(bit_out == exp_bits[rx_cnt], "R8", "decoded bit value",
                      int'(bit_out), int'(exp_bits[rx_cnt]));
                check(bit_out_n == ~exp_bits[rx_cnt], "R8", "complement output",
                      int'(bit_out_n), int'(~exp_bits[rx_cnt]));
            end else begin
                check(1'b0, "R8", "unexpected extra strobe", rx_cnt + 1, exp_cnt);
            end
            rx_cnt++;
        end
    end

    task automatic tog(input int n);
        repeat (n) @(negedge clk);
        f2f_in = ~f2f_in;
    endtask

    task automatic expect_bit(input bit b);
        exp_bits[exp_cnt] = b;
        exp_cnt++;
    endtask

    task automatic send_bit(input bit b, input int p);
        expect_bit(b);
        if (b) begin
            tog(p / 2);
            tog(p - p / 2);
        end else begin
            tog(p);
        end
    endtask

    task automatic start_card(input bit sl, input int p);
        skip_long = sl;
        exp_cnt = 0;
        rx_cnt = 0;
        tog(1);
        for (int i = 0; i < (sl ? 8 : 4); i++) tog(p);
    endtask

    task automatic end_card(input string tag);
        repeat (270) @(negedge clk);
        check(rx_cnt == exp_cnt, "R8", {tag, " bit count"}, rx_cnt, exp_cnt);
        check(card_present_n == 1'b1, "R9", {tag, " card released after quiet"},
              int'(card_present_n), 1);
    endtask

    function automatic int drift_period(input int i);
        int k;
        k = (i / 8) % 30;
        return 16 + ((k < 15) ? k : 30 - k);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (5) @(negedge clk);
        check(card_present_n == 1'b1, "R1", "card flag in reset", int'(card_present_n), 1);
        check(bit_strobe == 1'b0, "R1", "strobe in reset", int'(bit_strobe), 0);
        check(bit_out == 1'b0, "R1", "bit in reset", int'(bit_out), 0);
        check(bit_out_n == 1'b1, "R1", "complement in reset", int'(bit_out_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(card_present_n == 1'b1 && bit_strobe == 1'b0, "R1", "state after release",
              int'({card_present_n, bit_strobe}), 2);

        // R2 transitions inside the start-up window are ignored
        for (int i = 0; i < 9; i++) tog(3);
        repeat (60) @(negedge clk);
        check(card_present_n == 1'b1, "R2", "card flag after start-up toggles",
              int'(card_present_n), 1);
        check(rx_cnt == 0, "R2", "strobes during start-up", rx_cnt, 0);

        // R6 R7 R5 threshold and averaging, 4 lead-in cells of 20
        start_card(1'b0, 20);
        expect_bit(1'b1); tog(13); tog(7);   // R6: 130 < 140
        expect_bit(1'b0); tog(14);           // R7: 140 >= 140
        expect_bit(1'b0); tog(12);           // R5: ref 17, 120 >= 119
        expect_bit(1'b1); tog(9); tog(4);    // R5: ref 13, 90 < 91
        expect_bit(1'b0); tog(9);            // R5: ref floor 12, 90 >= 84
        repeat (150) @(negedge clk);
        check(card_present_n == 1'b0, "R9", "card still present before timeout",
              int'(card_present_n), 0);
        repeat (120) @(negedge clk);
        check(card_present_n == 1'b1, "R9", "card released after timeout",
              int'(card_present_n), 1);
        check(rx_cnt == exp_cnt, "R6", "threshold sequence count", rx_cnt, exp_cnt);

        // R4 only the last lead-in cell seeds the reference
        skip_long = 1'b0;
        exp_cnt = 0;
        rx_cnt = 0;
        tog(1);
        tog(40); tog(40); tog(40); tog(20);
        expect_bit(1'b0); tog(15);           // R4: ref 20, 150 >= 140
        expect_bit(1'b0); tog(20);
        end_card("R4 seed");

        // R3 eight lead-in cells, card flag timing; R8 strobe latency
        skip_long = 1'b1;
        exp_cnt = 0;
        rx_cnt = 0;
        tog(1);
        for (int i = 0; i < 7; i++) tog(20);
        check(card_present_n == 1'b1, "R3", "card after 7 of 8 lead-in cells",
              int'(card_present_n), 1);
        tog(20);
        repeat (2) @(negedge clk);
        check(card_present_n == 1'b1, "R3", "card two cycles after last lead-in edge",
              int'(card_present_n), 1);
        @(negedge clk);
        check(card_present_n == 1'b0, "R3", "card three cycles after last lead-in edge",
              int'(card_present_n), 0);
        expect_bit(1'b0);
        tog(17);
        repeat (2) @(negedge clk);
        check(bit_strobe == 1'b0, "R8", "strobe two cycles after boundary", int'(bit_strobe), 0);
        @(negedge clk);
        check(bit_strobe == 1'b1, "R8", "strobe three cycles after boundary", int'(bit_strobe), 1);
        @(negedge clk);
        check(bit_strobe == 1'b0, "R8", "strobe lasts one cycle", int'(bit_strobe), 0);
        send_bit(1'b1, 16);
        send_bit(1'b1, 20);
        send_bit(1'b0, 20);
        end_card("R3 long lead-in");

        // Sweep: every 6-bit pattern, both lead-in lengths, fixed and drifting rate
        for (int sl = 0; sl < 2; sl++) begin
            for (int mode = 0; mode < 3; mode++) begin
                int p0;
                int idx;
                p0 = (mode == 0) ? 16 : ((mode == 1) ? 24 : drift_period(0));
                start_card(sl[0], p0);
                idx = 0;
                for (int pat = 0; pat < 64; pat++) begin
                    for (int b = 5; b >= 0; b--) begin
                        int p;
                        p = (mode == 0) ? 16 : ((mode == 1) ? 24 : drift_period(idx));
                        send_bit(pat[b], p);
                        idx++;
                    end
                end
                end_card((sl == 0) ? "R7 sweep short lead-in" : "R6 sweep long lead-in");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule